// File: doc/BRIEF.md
# Next Program Counter Selection Unit

This block holds the program counter of a single-cycle 32-bit load/store processor. It works out the address of the next instruction in the same cycle. There are four kinds of next address: the sequential address, a conditional branch target, an absolute jump target and a jump target taken from a register. A two-bit source select picks one of them through a single multiplexer that has one input per kind. The branch enable together with the ALU zero flag qualifies the branch input. The jump enable qualifies both jump inputs.

All address arithmetic is combinational. The only state is the program counter register, which takes the chosen address at the rising clock edge. Instruction memory, the register file and the ALU are outside the block. The core feeds in the low 26 bits of the current instruction word, the control signals, the zero flag and a register operand. It reads back the current PC, the PC plus four (used as the return address by link instructions) and the next PC.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `pc_q` becomes 0x00000000 after that edge.
- R2: `pc_plus4` always equals `pc_q + 4`. With select 2'b00, `pc_next` equals `pc_plus4` whatever the enables and the zero flag are.
- R3: With select 2'b01, `branch_en` high and `alu_zero` high, `pc_next` equals `pc_plus4` plus the sign-extended value of `instr_low[15:0]` shifted left by two.
- R4: With select 2'b01 and either `branch_en` or `alu_zero` low, `pc_next` equals `pc_plus4`.
- R5: With select 2'b10 and `jump_en` high, `pc_next` is `pc_plus4[31:28]`, then `instr_low[25:0]`, then two zero bits, from most significant to least significant.
- R6: With select 2'b11 and `jump_en` high, `pc_next` equals `reg_target` on all 32 bits, with no alignment applied.
- R7: With select 2'b10 or 2'b11 and `jump_en` low, `pc_next` equals `pc_plus4`.
- R8: At every rising edge where `rst_n` is high, `pc_q` takes the value `pc_next` had just before that edge.
- R9: All address sums wrap modulo 2^32. For example, `pc_q` = 0xFFFFFFFC gives `pc_plus4` = 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_low | input | 26 | Low 26 bits of the current instruction word (jump index; the low 16 bits are the branch offset) |
| branch_en | input | 1 | Branch control from the decoder |
| jump_en | input | 1 | Jump control, for both the absolute and the register jumps |
| pc_src_sel | input | 2 | Next-address source: 00 sequential, 01 branch, 10 jump, 11 register |
| alu_zero | input | 1 | Zero flag from the ALU compare |
| reg_target | input | 32 | Register operand used for register-indirect jumps |
| pc_q | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus four |
| pc_next | output | 32 | Address the PC takes at the next edge |

## Verification
The only state in this block is the PC register, so any wrong internal value reaches `pc_q` one edge later. It also reaches `pc_plus4` and `pc_next` in the same cycle, because both are derived from the register. A wrong source choice or a wrong target computation appears combinationally on `pc_next`, in the cycle where the instruction is presented. From then on the error is carried into every later PC, so the bench can report it at once: it compares all three outputs with its own model on every clock. Random streams cover each select value with every combination of enables and zero flag. Directed steps cover reset, a backward branch and the wrap at the top of the address space.

// File: rtl/pcu_pkg.sv
// Shared definitions for the next-PC unit.
// Assumes a two-bit source select with four fixed codes.
package pcu_pkg;

    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 4;

    // Code order fixes the multiplexer input index of each source.
    typedef enum logic [SEL_W-1:0] {
        SRC_SEQ    = 2'b00,
        SRC_BRANCH = 2'b01,
        SRC_JUMP   = 2'b10,
        SRC_REG    = 2'b11
    } pc_src_e;

endpackage

// File: rtl/pcu_target_gen.sv
// Computes the candidate next addresses from the current PC.
// Assumes instructions of INSTR_BYTES bytes, with the branch offset in the
// low IMM_W bits and the jump index in the low IDX_W bits of the word.
module pcu_target_gen #(
    parameter int XLEN        = 32,
    parameter int INSTR_BYTES = 4,
    parameter int IMM_W       = 16,
    parameter int IDX_W       = 26
) (
    input  logic [XLEN-1:0]  pc_q,
    input  logic [IDX_W-1:0] instr_low,
    output logic [XLEN-1:0]  seq_addr,
    output logic [XLEN-1:0]  br_addr,
    output logic [XLEN-1:0]  jmp_addr
);

    localparam int SHIFT  = $clog2(INSTR_BYTES);
    localparam int SEXT_W = XLEN - IMM_W - SHIFT;
    localparam int HI_W   = XLEN - IDX_W - SHIFT;

    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0]  offset;

    // Sequential address, branch displacement and both targets.
    always_comb begin
        imm      = instr_low[IMM_W-1:0];
        seq_addr = pc_q + XLEN'(INSTR_BYTES);
        offset   = {{SEXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
        br_addr  = seq_addr + offset;
        jmp_addr = {seq_addr[XLEN-1 -: HI_W], instr_low, {SHIFT{1'b0}}};
    end

endmodule

// File: rtl/pcu_src_qualify.sv
// Turns the raw source select into the effective one. A branch that is not
// both enabled and taken, or a jump with the jump control low, falls back
// to the sequential address.
module pcu_src_qualify
    import pcu_pkg::*;
(
    input  pc_src_e sel_raw,
    input  logic    branch_en,
    input  logic    jump_en,
    input  logic    alu_zero,
    output pc_src_e sel_eff
);

    // Apply the enable gating for each kind of source.
    always_comb begin
        unique case (sel_raw)
            SRC_BRANCH: sel_eff = (branch_en && alu_zero) ? SRC_BRANCH : SRC_SEQ;
            SRC_JUMP:   sel_eff = jump_en ? SRC_JUMP : SRC_SEQ;
            SRC_REG:    sel_eff = jump_en ? SRC_REG : SRC_SEQ;
            default:    sel_eff = SRC_SEQ;
        endcase
    end

endmodule

// File: rtl/pcu_src_mux.sv
// Multiplexer with one input per next-address kind, built as a one-hot
// AND-OR. Assumes every select code has its own input.
module pcu_src_mux #(
    parameter int XLEN    = 32,
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0][XLEN-1:0] cand,
    input  logic [SEL_W-1:0]             sel,
    output logic [XLEN-1:0]              addr
);

    logic [NUM_SRC-1:0] hot;

    // One decode line per input.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
        assign hot[g] = (sel == SEL_W'(g));
    end

    // OR together the one input that is enabled.
    always_comb begin
        addr = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            addr = addr | (cand[i] & {XLEN{hot[i]}});
        end
    end

endmodule

// File: rtl/pcu_pc_reg.sv
// Program counter register with a synchronous active-low reset.
// Assumes the reset address is aligned to an instruction.
module pcu_pc_reg #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] d,
    output logic [XLEN-1:0] q
);

    // Load the reset address, or capture the next PC at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_ADDR;
        else        q <= d;
    end

endmodule

// File: rtl/pc_next_unit.sv
// Next program counter selection unit: holds the PC and selects the next
// instruction address among sequential, branch, jump and register targets.
// Assumes single-cycle use: every input is valid for the whole cycle.
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              INSTR_BYTES = 4,
    parameter int              IMM_W       = 16,
    parameter int              IDX_W       = 26,
    parameter logic [XLEN-1:0] RESET_ADDR  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] instr_low,
    input  logic             branch_en,
    input  logic             jump_en,
    input  logic [SEL_W-1:0] pc_src_sel,
    input  logic             alu_zero,
    input  logic [XLEN-1:0]  reg_target,
    output logic [XLEN-1:0]  pc_q,
    output logic [XLEN-1:0]  pc_plus4,
    output logic [XLEN-1:0]  pc_next
);

    localparam int SHIFT = $clog2(INSTR_BYTES);
    localparam int HI_W  = XLEN - IDX_W - SHIFT;

    logic [XLEN-1:0]              seq_addr, br_addr, jmp_addr;
    logic [NUM_SRC-1:0][XLEN-1:0] cand;
    pc_src_e                      sel_eff;

    pcu_target_gen #(
        .XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES), .IMM_W(IMM_W), .IDX_W(IDX_W)
    ) u_targets (
        .pc_q(pc_q), .instr_low(instr_low),
        .seq_addr(seq_addr), .br_addr(br_addr), .jmp_addr(jmp_addr)
    );

    pcu_src_qualify u_qualify (
        .sel_raw(pc_src_e'(pc_src_sel)), .branch_en(branch_en),
        .jump_en(jump_en), .alu_zero(alu_zero), .sel_eff(sel_eff)
    );

    // Place each candidate on the mux input its select code names.
    always_comb begin
        cand             = '0;
        cand[SRC_SEQ]    = seq_addr;
        cand[SRC_BRANCH] = br_addr;
        cand[SRC_JUMP]   = jmp_addr;
        cand[SRC_REG]    = reg_target;
    end

    pcu_src_mux #(
        .XLEN(XLEN), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)
    ) u_mux (
        .cand(cand), .sel(sel_eff), .addr(pc_next)
    );

    pcu_pc_reg #(
        .XLEN(XLEN), .RESET_ADDR(RESET_ADDR)
    ) u_pc (
        .clk(clk), .rst_n(rst_n), .d(pc_next), .q(pc_q)
    );

    assign pc_plus4 = seq_addr;

    // Port-level checks on the selection and the register.
    p_plus4_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_plus4 == pc_q + XLEN'(INSTR_BYTES));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src_sel == SRC_SEQ) |=> (pc_q == $past(pc_q) + XLEN'(INSTR_BYTES)));

    p_branch_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src_sel == SRC_BRANCH && !(branch_en && alu_zero)) |-> (pc_next == pc_plus4));

    p_branch_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src_sel == SRC_BRANCH && branch_en && alu_zero)
            |-> (pc_next - pc_plus4 == XLEN'($signed(instr_low[IMM_W-1:0])) <<< SHIFT));

    p_jump_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src_sel == SRC_JUMP && jump_en)
            |-> (pc_next[XLEN-1 -: HI_W] == pc_plus4[XLEN-1 -: HI_W]
                 && pc_next[SHIFT +: IDX_W] == instr_low));

    p_reg_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src_sel == SRC_REG && jump_en) |-> (pc_next == reg_target));

    p_jump_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src_sel[1] && !jump_en) |-> (pc_next == pc_plus4));

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pc_q == $past(pc_next)));

endmodule

// File: tb/pc_next_unit_bench.sv
// Bench: behavioural next-PC model compared with all outputs every cycle.
module pc_next_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [25:0] instr_low;
    logic        branch_en, jump_en, alu_zero;
    logic [1:0]  pc_src_sel;
    logic [31:0] reg_target;
    logic [31:0] pc_q, pc_plus4, pc_next;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] m_pc;

    always #2 clk = ~clk;

    pc_next_unit u_pc_next_unit (
        .clk(clk), .rst_n(rst_n), .instr_low(instr_low),
        .branch_en(branch_en), .jump_en(jump_en), .pc_src_sel(pc_src_sel),
        .alu_zero(alu_zero), .reg_target(reg_target),
        .pc_q(pc_q), .pc_plus4(pc_plus4), .pc_next(pc_next)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs, compare all outputs, then step the model.
    task automatic step(input logic rn, input logic [1:0] sel, input logic be,
                        input logic je, input logic z, input logic [25:0] il,
                        input logic [31:0] rt);
        logic [31:0] p4, exp_next, off;
        string       tag;
        @(negedge clk);
        rst_n = rn; pc_src_sel = sel; branch_en = be; jump_en = je;
        alu_zero = z; instr_low = il; reg_target = rt;
        #1;
        p4  = m_pc + 32'd4;
        off = {{14{il[15]}}, il[15:0], 2'b00};
        exp_next = p4; tag = "R2";
        if (sel == 2'b01) begin
            if (be && z) begin exp_next = p4 + off; tag = "R3"; end
            else tag = "R4";
        end else if (sel == 2'b10) begin
            if (je) begin exp_next = {p4[31:28], il, 2'b00}; tag = "R5"; end
            else tag = "R7";
        end else if (sel == 2'b11) begin
            if (je) begin exp_next = rt; tag = "R6"; end
            else tag = "R7";
        end
        check("R8 pc_q", pc_q, m_pc);
        check(m_pc == 32'hFFFFFFFC ? "R9 pc_plus4 wrap" : "R2 pc_plus4", pc_plus4, p4);
        check(tag, pc_next, exp_next);
        @(posedge clk);
        m_pc = rn ? exp_next : 32'h0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pc_src_sel = 2'b00; branch_en = 1'b0; jump_en = 1'b0;
        alu_zero = 1'b0; instr_low = '0; reg_target = '0;
        repeat (3) @(posedge clk);
        m_pc = 32'h0;
        @(negedge clk);
        check("R1 reset pc", pc_q, 32'h0);

        // Sequential, fallback and gated-jump cases.
        step(1, 2'b00, 1, 1, 1, 26'h3FFFFFF, 32'h1234);
        step(1, 2'b01, 1, 0, 0, 26'h0010, 32'h0);
        step(1, 2'b01, 0, 0, 1, 26'h0010, 32'h0);
        step(1, 2'b10, 0, 0, 0, 26'h12345, 32'h0);
        step(1, 2'b11, 0, 0, 0, 26'h0, 32'hDEAD0000);
        // Backward taken branch, absolute jump, register jump.
        step(1, 2'b01, 1, 0, 1, 26'h0FFFC, 32'h0);
        step(1, 2'b10, 0, 1, 0, 26'h2ABCDEF, 32'h0);
        step(1, 2'b11, 0, 1, 0, 26'h0, 32'hFFFFFFFC);
        // Wrap at the top of the address space (R9).
        step(1, 2'b00, 0, 0, 0, 26'h0, 32'h0);
        step(1, 2'b00, 0, 0, 0, 26'h0, 32'h0);
        // Register jump to an unaligned value.
        step(1, 2'b11, 0, 1, 0, 26'h0, 32'h80000003);
        step(1, 2'b10, 0, 1, 0, 26'h1, 32'h0);
        // Reset in mid-run (R1).
        step(0, 2'b11, 0, 1, 0, 26'h0, 32'h40);
        step(1, 2'b00, 0, 0, 0, 26'h0, 32'h0);

        // Random instruction stream with occasional resets.
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 100) != 0, 2'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 26'($urandom), $urandom & 32'hFFFFFFFC);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule